// File: doc/BRIEF.md
# Synchronizing Instruction Completion Sequencer

This block decides when two kinds of synchronizing instruction may complete. The first is a full memory barrier. It takes a fixed minimum number of cycles when nothing is waiting to be written. When stores are still queued, it also waits for the pending-store count to reach zero. When bus broadcast is enabled, it must then see a successful broadcast on the bus. A broadcast that reports failure is retried with no outside help. The order is always store drain, then broadcast, then finish.

The second kind is an invalidate-synchronize instruction. It never occupies an execution unit. The sequencer flags it finished in the same cycle it is dispatched and then holds it. When it reaches the head of retirement, it may retire only while an external synchronize line is high. With that line tied high it costs nothing.

Only one synchronizing instruction is tracked at a time. A busy output tells the dispatcher to hold back a second one. A dispatch presented while busy is dropped.

Top module: `sync_complete_seq`

## Requirements
- R1: A barrier (`disp_kind` = 0) accepted at clock edge E0, with `st_pend` zero and `bcast_en` low, raises `finished` for exactly one cycle, in the cycle that follows edge E(MIN_LAT). `busy` is high from E0 through that cycle and low after the next edge.
- R2: When `st_pend` is first sampled as zero at edge Ek (k ≥ 1) and broadcast is disabled, `finished` is raised in the cycle after edge E(max(k+1, MIN_LAT)). It is never raised earlier.
- R3: With `bcast_en` high, `bcast_req` rises only in the cycle after the edge that first samples `st_pend` as zero. It stays high until an edge samples `bcast_done` and `bcast_ok` both high. `finished` follows in the cycle after the next edge, subject to the MIN_LAT floor.
- R4: A `bcast_done` pulse with `bcast_ok` low keeps `bcast_req` high (a retry) and does not finish the barrier.
- R5: An invalidate-synchronize (`disp_kind` = 1) accepted while idle raises `finished` combinationally in its dispatch cycle. It then holds `busy` high.
- R6: A held invalidate-synchronize drives `retire_ready` high exactly while `retire_head` and `ext_sync` are both high. It clears `busy` after the edge that samples `retire_ready`. With `ext_sync` held high, `retire_ready` follows `retire_head` at once.
- R7: A dispatch presented while `busy` is high is ignored. It raises no `finished`, and it leaves nothing pending once the current instruction completes.
- R8: While `rst_n` is low, `busy`, `finished`, `bcast_req` and `retire_ready` are low. This holds even when reset arrives in the middle of a barrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_vld | input | 1 | Dispatch strobe for a synchronizing instruction |
| disp_kind | input | 1 | 0 = memory barrier, 1 = invalidate-synchronize |
| st_pend | input | CNT_W | Number of stores not yet written to memory |
| bcast_en | input | 1 | Barrier must be broadcast on the bus |
| bcast_done | input | 1 | Bus reports the broadcast attempt has ended |
| bcast_ok | input | 1 | Qualifies `bcast_done`: attempt succeeded |
| retire_head | input | 1 | Held invalidate-synchronize is at retirement head |
| ext_sync | input | 1 | External synchronize line |
| busy | output | 1 | A synchronizing instruction is in progress |
| finished | output | 1 | Instruction finished this cycle |
| bcast_req | output | 1 | Broadcast request to the bus |
| retire_ready | output | 1 | Held invalidate-synchronize may retire |

## Verification
The bench builds the block with CNT_W = 4 and MIN_LAT = 3. A three-cycle floor is short enough that short drains (one store cycle) are absorbed by the floor. Longer drains (two or more) push completion past it, so both sides of the max() in R2 are visible. The same floor lets a broadcast that succeeds at once still land exactly on the minimum latency. A four-bit store count keeps the non-zero values that are driven cheap, while the zero test still spans every bit.

// File: rtl/sync_complete_pkg.sv
// Shared types for the synchronizing-instruction completion sequencer.
// Assumes: nothing beyond standard SystemVerilog enum support.
package sync_complete_pkg;

    // Barrier progress states, in the order a barrier walks them.
    typedef enum logic [2:0] {
        BAR_IDLE  = 3'd0,
        BAR_DRAIN = 3'd1,
        BAR_BCAST = 3'd2,
        BAR_HOLD  = 3'd3,
        BAR_DONE  = 3'd4
    } bar_state_t;

    // Kind of synchronizing instruction presented at dispatch.
    typedef enum logic {
        KIND_BARRIER = 1'b0,
        KIND_TSYNC   = 1'b1
    } sync_kind_t;

endpackage

// File: rtl/scs_elapsed.sv
// Counts cycles since a barrier was accepted, saturating at MIN_LAT.
// Reports when the minimum barrier latency has been reached.
// Assumes: start pulses for one cycle at acceptance; MIN_LAT >= 2.
module scs_elapsed #(
    parameter int unsigned MIN_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic reached
);
    localparam int unsigned LAT_W = $clog2(MIN_LAT + 1);
    localparam logic [LAT_W-1:0] LAT_MAX = LAT_W'(MIN_LAT);
    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

    logic [LAT_W-1:0] count_q;

    // Load one on acceptance, then count up until the floor is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (start) begin
            count_q <= LAT_ONE;
        end else if (count_q != '0 && count_q < LAT_MAX) begin
            count_q <= count_q + LAT_ONE;
        end
    end

    // Floor reached once the count equals the minimum latency.
    always_comb begin
        reached = (count_q >= LAT_MAX);
    end
endmodule

// File: rtl/scs_barrier.sv
// Barrier sequencing FSM: drain stores, optionally broadcast with retry,
// respect the latency floor, then flag the barrier finished for one cycle.
// Assumes: start only arrives while idle; bcast_ok is only meaningful with bcast_done.
module scs_barrier #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] st_pend,
    input  logic             bcast_en,
    input  logic             bcast_done,
    input  logic             bcast_ok,
    input  logic             lat_reached,
    output logic             busy,
    output logic             finished,
    output logic             bcast_req
);
    import sync_complete_pkg::*;

    bar_state_t state_q, state_d;
    logic       drained;
    logic       bcast_success;

    // Qualify the drain and broadcast outcomes.
    always_comb begin
        drained       = (st_pend == '0);
        bcast_success = bcast_done & bcast_ok;
    end

    // Next-state selection for the barrier walk.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BAR_IDLE:  if (start)         state_d = BAR_DRAIN;
            BAR_DRAIN: if (drained)       state_d = bcast_en ? BAR_BCAST : BAR_HOLD;
            BAR_BCAST: if (bcast_success) state_d = BAR_HOLD;
            BAR_HOLD:  if (lat_reached)   state_d = BAR_DONE;
            BAR_DONE:                     state_d = BAR_IDLE;
            default:                      state_d = BAR_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BAR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode outputs from the current state.
    always_comb begin
        busy      = (state_q != BAR_IDLE);
        bcast_req = (state_q == BAR_BCAST);
        finished  = (state_q == BAR_DONE);
    end
endmodule

// File: rtl/scs_tsync.sv
// Holds an invalidate-synchronize between dispatch and retirement and
// gates its retirement on the external synchronize line.
// Assumes: start only arrives while the sequencer is idle.
module scs_tsync (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic retire_head,
    input  logic ext_sync,
    output logic pending,
    output logic retire_ready
);
    // Retirement allowed only for a held instruction with the line high.
    always_comb begin
        retire_ready = pending & retire_head & ext_sync;
    end

    // Set on dispatch, clear when retirement is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (start) begin
            pending <= 1'b1;
        end else if (retire_ready) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_complete_seq.sv
// Top of the synchronizing-instruction completion sequencer. Accepts one
// synchronizing instruction at a time, steers it to the barrier FSM or the
// invalidate-synchronize holder, and merges their finish and busy signals.
// Assumes: the dispatcher honours busy; a dispatch while busy is dropped.
module sync_complete_seq #(
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned MIN_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_vld,
    input  logic             disp_kind,
    input  logic [CNT_W-1:0] st_pend,
    input  logic             bcast_en,
    input  logic             bcast_done,
    input  logic             bcast_ok,
    input  logic             retire_head,
    input  logic             ext_sync,
    output logic             busy,
    output logic             finished,
    output logic             bcast_req,
    output logic             retire_ready
);
    import sync_complete_pkg::*;

    logic accept;
    logic bar_start;
    logic ts_start;
    logic bar_busy;
    logic bar_finished;
    logic ts_pending;
    logic lat_reached;

    // Accept a dispatch only when nothing is in progress, then split by kind.
    always_comb begin
        accept    = disp_vld & ~busy;
        bar_start = accept & (sync_kind_t'(disp_kind) == KIND_BARRIER);
        ts_start  = accept & (sync_kind_t'(disp_kind) == KIND_TSYNC);
    end

    // Merge status: invalidate-synchronize finishes at dispatch.
    always_comb begin
        busy     = bar_busy | ts_pending;
        finished = bar_finished | ts_start;
    end

    scs_elapsed #(
        .MIN_LAT (MIN_LAT)
    ) u_elapsed (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bar_start),
        .reached (lat_reached)
    );

    scs_barrier #(
        .CNT_W (CNT_W)
    ) u_barrier (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (bar_start),
        .st_pend     (st_pend),
        .bcast_en    (bcast_en),
        .bcast_done  (bcast_done),
        .bcast_ok    (bcast_ok),
        .lat_reached (lat_reached),
        .busy        (bar_busy),
        .finished    (bar_finished),
        .bcast_req   (bcast_req)
    );

    scs_tsync u_tsync (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (ts_start),
        .retire_head  (retire_head),
        .ext_sync     (ext_sync),
        .pending      (ts_pending),
        .retire_ready (retire_ready)
    );
endmodule

// File: rtl/sync_complete_checker.sv
// Protocol checks for the completion sequencer, bound to the top module.
// Assumes: signal names match the top module's ports and internal nets.
module sync_complete_checker #(
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             accept,
    input logic [CNT_W-1:0] st_pend,
    input logic             bcast_req,
    input logic             bcast_done,
    input logic             bcast_ok,
    input logic             finished,
    input logic             bar_finished,
    input logic             retire_ready,
    input logic             retire_head,
    input logic             ext_sync
);
    // Barrier finish is a single-cycle pulse.
    assert_single_finish_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bar_finished |=> !bar_finished);

    // Broadcast only starts once the store count was seen empty.
    assert_bcast_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcast_req) |-> ($past(st_pend) == '0));

    // While broadcasting, the barrier is in progress and not finished.
    assert_bcast_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_req |-> (busy && !finished));

    // A failed attempt keeps the request up for a retry.
    assert_bcast_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_req && bcast_done && !bcast_ok) |=> bcast_req);

    // Retirement only with the instruction at the head and the line high.
    assert_retire_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ready |-> (retire_head && ext_sync));

    // Retirement releases the sequencer at the next edge.
    assert_retire_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_ready |=> !busy);

    // No dispatch is taken while something is in progress.
    assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
endmodule

bind sync_complete_seq sync_complete_checker #(.CNT_W(CNT_W)) u_checker (.*);

// File: tb/sync_complete_seq_bench.sv
module sync_complete_seq_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned CNT_W   = 4;
    localparam int unsigned MIN_LAT = 3;
    localparam int NV = 8;
    // Columns: stores-busy cycles D, broadcast enable, failed attempts F, expected finish edge.
    localparam int VEC [NV][4] = '{
        '{0, 0, 0, 3}, '{1, 0, 0, 3}, '{2, 0, 0, 4}, '{5, 0, 0, 7},
        '{0, 1, 0, 3}, '{0, 1, 2, 5}, '{3, 1, 0, 6}, '{2, 1, 3, 8}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             disp_vld = 1'b0;
    logic             disp_kind = 1'b0;
    logic [CNT_W-1:0] st_pend = '0;
    logic             bcast_en = 1'b0;
    logic             bcast_done = 1'b0;
    logic             bcast_ok = 1'b0;
    logic             retire_head = 1'b0;
    logic             ext_sync = 1'b0;
    logic             busy, finished, bcast_req, retire_ready;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit reported = 1'b0;

    sync_complete_seq #(.CNT_W(CNT_W), .MIN_LAT(MIN_LAT)) u_sync_complete_seq (
        .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_kind(disp_kind),
        .st_pend(st_pend), .bcast_en(bcast_en), .bcast_done(bcast_done),
        .bcast_ok(bcast_ok), .retire_head(retire_head), .ext_sync(ext_sync),
        .busy(busy), .finished(finished), .bcast_req(bcast_req),
        .retire_ready(retire_ready)
    );

    always #2 clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=expired exp=finished");
            report();
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: act=%0b exp=%0b", tag, what, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_vec(int d, int en, int fl, int f);
        int k = d + 1;
        int s = k + fl + 1;
        string tag;
        if (en == 0 && d == 0) tag = "R1";
        else if (en == 0)      tag = "R2";
        else if (fl == 0)      tag = "R3";
        else                   tag = "R4";
        disp_vld  = 1'b1;
        disp_kind = 1'b0;
        bcast_en  = (en != 0);
        st_pend   = (d > 0) ? CNT_W'(5) : '0;
        tick();
        disp_vld = 1'b0;
        for (int n = 0; n <= f + 1; n++) begin
            int nx = n + 1;
            st_pend    = (nx <= d) ? CNT_W'(5) : '0;
            bcast_done = (en != 0) && nx >= k + 1 && nx <= s;
            bcast_ok   = (en != 0) && nx == s;
            #0.5;
            chk(tag, "finished", finished, n == f);
            chk(tag, "busy", busy, n <= f);
            chk(tag, "bcast_req", bcast_req, (en != 0) && n >= k && n < s);
            tick();
        end
        bcast_done = 1'b0;
        bcast_ok   = 1'b0;
        st_pend    = '0;
        bcast_en   = 1'b0;
    endtask

    initial begin
        // R8: reset state
        tick();
        #0.5;
        chk("R8", "busy", busy, 1'b0);
        chk("R8", "finished", finished, 1'b0);
        chk("R8", "bcast_req", bcast_req, 1'b0);
        chk("R8", "retire_ready", retire_ready, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();

        // Vector table: barrier timing over drain and broadcast patterns.
        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
        end

        // R5 / R6: invalidate-synchronize finished at dispatch, gated at retirement.
        disp_vld = 1'b1; disp_kind = 1'b1;
        #0.5;
        chk("R5", "finished at dispatch", finished, 1'b1);
        tick();
        disp_vld = 1'b0;
        #0.5;
        chk("R5", "finished after dispatch", finished, 1'b0);
        chk("R5", "busy while held", busy, 1'b1);
        retire_head = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            #0.5;
            chk("R6", "retire_ready with line low", retire_ready, 1'b0);
            chk("R6", "busy with line low", busy, 1'b1);
        end
        ext_sync = 1'b1;
        #0.5;
        chk("R6", "retire_ready with line high", retire_ready, 1'b1);
        tick();
        #0.5;
        chk("R6", "busy after retire", busy, 1'b0);
        chk("R6", "retire_ready after retire", retire_ready, 1'b0);

        // R6: line tied high behaves as a no-op.
        retire_head = 1'b0;
        disp_vld = 1'b1; disp_kind = 1'b1;
        tick();
        disp_vld = 1'b0;
        retire_head = 1'b1;
        #0.5;
        chk("R6", "no-op retire", retire_ready, 1'b1);
        tick();
        #0.5;
        chk("R6", "no-op release", busy, 1'b0);
        retire_head = 1'b0;
        ext_sync = 1'b0;

        // R7: dispatch while a barrier is in progress is dropped.
        disp_vld = 1'b1; disp_kind = 1'b0;
        tick();
        disp_kind = 1'b1;
        for (int n = 0; n <= 4; n++) begin
            if (n == 2) disp_vld = 1'b0;
            if (n == 4) begin retire_head = 1'b1; ext_sync = 1'b1; end
            #0.5;
            if (n < 3) chk("R7", "no finish for dropped dispatch", finished, 1'b0);
            if (n == 3) chk("R7", "barrier still finishes", finished, 1'b1);
            if (n == 4) begin
                chk("R7", "idle afterwards", busy, 1'b0);
                chk("R7", "nothing held", retire_ready, 1'b0);
            end
            tick();
        end
        retire_head = 1'b0; ext_sync = 1'b0;

        // R8: reset in the middle of a broadcasting barrier.
        disp_vld = 1'b1; disp_kind = 1'b0; bcast_en = 1'b1; st_pend = '0;
        tick();
        disp_vld = 1'b0;
        tick();
        #0.5;
        chk("R3", "request before reset", bcast_req, 1'b1);
        rst_n = 1'b0;
        tick();
        #0.5;
        chk("R8", "busy in reset", busy, 1'b0);
        chk("R8", "bcast_req in reset", bcast_req, 1'b0);
        chk("R8", "finished in reset", finished, 1'b0);
        rst_n = 1'b1;
        bcast_en = 1'b0;
        tick();
        #0.5;
        chk("R8", "idle after release", busy, 1'b0);

        report();
    end
endmodule